// File: doc/BRIEF.md
# Dual-Page I2C Configuration Memory

This block is an I2C target that answers at two neighbouring device addresses and gives the bus master access to 512 bytes of configuration storage. Each device address opens its own 256-byte page. A master first sends the device address with the write flag, then one byte that loads the offset pointer. After that it either streams data bytes into the page, or it issues a repeated START with the read flag and streams bytes back out. The pointer steps after every byte and wraps inside the page that is currently open. SCL and SDA are oversampled on the system clock. SDA is open-drain: the block only ever pulls the line low.

Most of the storage is plain nonvolatile user memory, modelled as a register array that reset does not clear. Six bytes on the first page are volatile control registers that reset clears. Two ranges are reserved: they read as all ones and discard writes. Bit 0 of a mode byte on the first page switches one byte of the second page from ordinary memory to a live, read-only status byte that carries the loss-of-signal input. A write-protect input freezes the whole array. Protected writes are still acknowledged.

Top module: `dual_page_i2c_mem`

## Requirements
- R1: A device address byte of A0h or A1h opens page 0, and A2h or A3h opens page 1 (bit 0 is the read flag). Any other address byte is not acknowledged: SDA stays released in the acknowledge slot, and the bytes that follow up to the next START are ignored.
- R2: The block acknowledges, by pulling SDA low in the ninth clock, the device address byte, the offset byte and every write data byte. SDA changes only after a falling edge of SCL, or at a START or STOP.
- R3: Sequential writes and reads advance the offset pointer by one per byte. The pointer wraps from FFh to 00h inside the same page.
- R4: A write transfer that carries only the offset byte, followed by a repeated START and a read address, reads from that offset. A read that starts without an offset byte continues from the current pointer.
- R5: Page 0 offsets 78h–79h and page 1 offsets F0h–FFh read as FFh, and writes to them are discarded.
- R6: Page 0 offsets 7Ah–7Fh are volatile and read 00h after reset. Nonvolatile bytes keep their contents across reset.
- R7: When bit 0 of page 0 offset 75h is 1, page 1 offset 6Eh reads as {7'b0, loss-of-signal level} and discards writes. When that bit is 0, 6Eh is ordinary memory that still holds the byte last stored there.
- R8: While the write-protect input is high, no location changes, the mode byte included, and data bytes are still acknowledged.
- R9: A STOP at any point returns the block to idle with SDA released, and a partial data byte is discarded. A START at any point begins a new address phase. After reset SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | High pulls SDA low (open-drain drive) |
| wp_i | input | 1 | Write protect: high blocks every write |
| los_i | input | 1 | Loss-of-signal level shown in the status byte |

## Verification
The bench builds the block with its default parameters: device addresses 50h and 51h (A0h and A2h on the wire), and two synchronizer stages. It runs the bus at twelve system clocks per bit. This setting makes a full sweep cheap enough to cover all 512 byte locations in both directions. The sweep also carries a 256-byte write burst that wraps, so every reserved, volatile, mode and status location is reached through the normal transfer path, against a model array kept in the bench. Directed transfers then cover the mode switch with both loss-of-signal levels, write protection, a foreign device address, a STOP in the middle of a byte, reads from the current pointer, and a reset between transfers.

// File: rtl/cfgmem_pkg.sv
`timescale 1ns/1ps
package cfgmem_pkg;

    localparam int BYTE_W    = 8;
    localparam int OFF_W     = 8;
    localparam int PAGE_SIZE = 2 ** OFF_W;
    localparam int MEM_DEPTH = 2 * PAGE_SIZE;
    localparam int CNT_W     = $clog2(BYTE_W + 1);

    // Offsets whose position the behaviour depends on
    localparam logic [OFF_W-1:0] MODE_OFF   = 8'h75;
    localparam logic [OFF_W-1:0] STATUS_OFF = 8'h6E;
    localparam logic [OFF_W-1:0] HOLE_A_LO  = 8'h78;
    localparam logic [OFF_W-1:0] HOLE_A_HI  = 8'h79;
    localparam logic [OFF_W-1:0] VOL_LO     = 8'h7A;
    localparam logic [OFF_W-1:0] VOL_HI     = 8'h7F;
    localparam logic [OFF_W-1:0] HOLE_B_LO  = 8'hF0;

    localparam int VOL_COUNT = int'(VOL_HI) - int'(VOL_LO) + 1;
    localparam int VOL_IDX_W = $clog2(VOL_COUNT);
    localparam int MODE_IDX  = int'(MODE_OFF);

    typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK} bus_state_e;
    typedef enum logic [1:0] {RX_DEV, RX_MEM, RX_DATA} rx_kind_e;
    typedef enum logic [1:0] {RG_NV, RG_VOL, RG_RSVD, RG_STATUS} region_e;

    typedef struct packed {
        logic             page;
        logic [OFF_W-1:0] off;
    } mem_addr_t;

    function automatic region_e classify(input mem_addr_t a, input logic sff);
        region_e r;
        r = RG_NV;
        if (!a.page) begin
            if (a.off >= HOLE_A_LO && a.off <= HOLE_A_HI) r = RG_RSVD;
            else if (a.off >= VOL_LO && a.off <= VOL_HI)  r = RG_VOL;
        end else begin
            if (a.off >= HOLE_B_LO)                       r = RG_RSVD;
            else if (sff && a.off == STATUS_OFF)          r = RG_STATUS;
        end
        return r;
    endfunction

    function automatic logic [VOL_IDX_W-1:0] vol_index(input logic [OFF_W-1:0] off);
        return VOL_IDX_W'(off - VOL_LO);
    endfunction

endpackage

// File: rtl/cfgmem_sync.sv
`timescale 1ns/1ps
module cfgmem_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] pipe_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) pipe_q[s] <= RST_VAL;
        end else begin
            pipe_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
        end
    end

    assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/cfgmem_line_events.sv
`timescale 1ns/1ps
module cfgmem_line_events #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic [1:0] lines_s;
    logic       scl_now, sda_now, scl_prev_q, sda_prev_q;

    cfgmem_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_line_sync (
        .clk (clk),
        .rst (rst),
        .d_i ({scl_i, sda_i}),
        .q_o (lines_s)
    );

    assign {scl_now, sda_now} = lines_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_prev_q <= scl_now;
            sda_prev_q <= sda_now;
        end
    end

    assign sda_o      = sda_now;
    assign scl_rise_o = scl_now & ~scl_prev_q;
    assign scl_fall_o = ~scl_now & scl_prev_q;
    assign start_o    = scl_now & scl_prev_q & sda_prev_q & ~sda_now;
    assign stop_o     = scl_now & scl_prev_q & ~sda_prev_q & sda_now;
endmodule

// File: rtl/cfgmem_map.sv
`timescale 1ns/1ps
module cfgmem_map
    import cfgmem_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  mem_addr_t         addr_i,
    input  logic              wr_en_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    input  logic              wp_i,
    input  logic              los_i,
    output logic [BYTE_W-1:0] rd_data_o
);
    logic [1:0]           pins_s;
    logic                 wp_s, los_s, sff, wr_ok;
    region_e              region;
    logic [VOL_IDX_W-1:0] vidx;
    logic [BYTE_W-1:0]    nv_q  [MEM_DEPTH];
    logic [BYTE_W-1:0]    vol_q [VOL_COUNT];

    cfgmem_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_pin_sync (
        .clk (clk),
        .rst (rst),
        .d_i ({wp_i, los_i}),
        .q_o (pins_s)
    );

    assign {wp_s, los_s} = pins_s;
    assign sff    = nv_q[MODE_IDX][0];
    assign region = classify(addr_i, sff);
    assign vidx   = vol_index(addr_i.off);
    assign wr_ok  = wr_en_i && !wp_s;

    // Nonvolatile array: contents survive reset
    always_ff @(posedge clk) begin
        if (wr_ok && region == RG_NV) nv_q[addr_i] <= wr_data_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < VOL_COUNT; i++) vol_q[i] <= '0;
        end else if (wr_ok && region == RG_VOL) begin
            vol_q[vidx] <= wr_data_i;
        end
    end

    always_comb begin
        unique case (region)
            RG_RSVD:   rd_data_o = '1;
            RG_STATUS: rd_data_o = {{(BYTE_W-1){1'b0}}, los_s};
            RG_VOL:    rd_data_o = vol_q[vidx];
            default:   rd_data_o = nv_q[addr_i];
        endcase
    end

    a_r5_reserved_reads_ones: assert property (@(posedge clk) disable iff (rst)
        (region == RG_RSVD) |-> (rd_data_o == 8'hFF));

    a_r7_status_follows_los: assert property (@(posedge clk) disable iff (rst)
        (addr_i.page && addr_i.off == STATUS_OFF && sff) |-> (rd_data_o == {7'b0, los_s}));

    a_r8_protect_holds_mode: assert property (@(posedge clk) disable iff (rst)
        wp_s |=> $stable(sff));
endmodule

// File: rtl/dual_page_i2c_mem.sv
`timescale 1ns/1ps
module dual_page_i2c_mem
    import cfgmem_pkg::*;
#(
    parameter logic [6:0] DEV_LO      = 7'h50,
    parameter logic [6:0] DEV_HI      = 7'h51,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe_o,
    input  logic wp_i,
    input  logic los_i
);
    localparam logic [CNT_W-1:0] BITS_FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] TX_LAST   = CNT_W'(BYTE_W - 1);

    logic sda_s, scl_rise, scl_fall, start_p, stop_p;

    bus_state_e        state_q;
    rx_kind_e          kind_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] shift_q, tx_q, rd_data;
    logic [OFF_W-1:0]  ptr_q;
    logic              page_q, rw_q, oe_q;
    logic              byte_in, dev_lo_hit, dev_hi_hit, wr_en;
    mem_addr_t         addr;

    cfgmem_line_events #(.SYNC_STAGES(SYNC_STAGES)) u_events (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_p),
        .stop_o     (stop_p)
    );

    assign addr       = '{page: page_q, off: ptr_q};
    assign byte_in    = (state_q == ST_RX) && scl_fall && (cnt_q == BITS_FULL);
    assign dev_lo_hit = (shift_q[7:1] == DEV_LO);
    assign dev_hi_hit = (shift_q[7:1] == DEV_HI);
    assign wr_en      = byte_in && (kind_q == RX_DATA);

    cfgmem_map #(.SYNC_STAGES(SYNC_STAGES)) u_map (
        .clk       (clk),
        .rst       (rst),
        .addr_i    (addr),
        .wr_en_i   (wr_en),
        .wr_data_i (shift_q),
        .wp_i      (wp_i),
        .los_i     (los_i),
        .rd_data_o (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            kind_q  <= RX_DEV;
            cnt_q   <= '0;
            shift_q <= '0;
            tx_q    <= '0;
            ptr_q   <= '0;
            page_q  <= 1'b0;
            rw_q    <= 1'b0;
            oe_q    <= 1'b0;
        end else if (start_p) begin
            state_q <= ST_RX;
            kind_q  <= RX_DEV;
            cnt_q   <= '0;
            oe_q    <= 1'b0;
        end else if (stop_p) begin
            state_q <= ST_IDLE;
            oe_q    <= 1'b0;
        end else begin
            unique case (state_q)
                ST_RX: begin
                    if (scl_rise && cnt_q != BITS_FULL) begin
                        shift_q <= {shift_q[BYTE_W-2:0], sda_s};
                        cnt_q   <= cnt_q + 1'b1;
                    end else if (byte_in) begin
                        cnt_q <= '0;
                        unique case (kind_q)
                            RX_DEV: begin
                                if (dev_lo_hit || dev_hi_hit) begin
                                    page_q  <= dev_hi_hit;
                                    rw_q    <= shift_q[0];
                                    kind_q  <= RX_MEM;
                                    state_q <= ST_ACK;
                                    oe_q    <= 1'b1;
                                end else begin
                                    state_q <= ST_IDLE;
                                end
                            end
                            RX_MEM: begin
                                ptr_q   <= shift_q;
                                kind_q  <= RX_DATA;
                                state_q <= ST_ACK;
                                oe_q    <= 1'b1;
                            end
                            default: begin
                                ptr_q   <= ptr_q + 1'b1;
                                state_q <= ST_ACK;
                                oe_q    <= 1'b1;
                            end
                        endcase
                    end
                end
                ST_ACK, ST_MACK: begin
                    if (state_q == ST_MACK && scl_rise && sda_s) begin
                        state_q <= ST_IDLE;
                    end else if (scl_fall) begin
                        if (rw_q) begin
                            tx_q    <= rd_data;
                            oe_q    <= ~rd_data[BYTE_W-1];
                            cnt_q   <= '0;
                            state_q <= ST_TX;
                        end else begin
                            oe_q    <= 1'b0;
                            state_q <= ST_RX;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (cnt_q == TX_LAST) begin
                            oe_q    <= 1'b0;
                            ptr_q   <= ptr_q + 1'b1;
                            cnt_q   <= '0;
                            state_q <= ST_MACK;
                        end else begin
                            tx_q  <= tx_q << 1;
                            oe_q  <= ~tx_q[BYTE_W-2];
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign sda_oe_o = oe_q;

    a_r9_stop_goes_idle: assert property (@(posedge clk) disable iff (rst)
        stop_p |=> (state_q == ST_IDLE));

    a_r2_idle_never_drives: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |-> !sda_oe_o);

    a_r2_drive_moves_after_fall: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe_o) |-> $past(scl_fall || start_p || stop_p));

    a_r1_foreign_address_nack: assert property (@(posedge clk) disable iff (rst)
        (byte_in && kind_q == RX_DEV && !dev_lo_hit && !dev_hi_hit)
        |=> (state_q == ST_IDLE && !sda_oe_o));
endmodule

// File: tb/test_dual_page_i2c_mem.sv
`timescale 1ns/1ps
module test_dual_page_i2c_mem;

    localparam int H = 6;   // system clocks per SCL phase
    localparam int Q = 3;   // offset of SDA updates and samples inside a phase

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0, los = 1'b0;
    logic sda_oe, sda_line;
    int   checks = 0, errors = 0;
    bit   done = 0;

    logic [7:0] model_q [512];
    logic       sff_m = 1'b0;
    logic       mpage = 1'b0;
    logic [7:0] mptr  = 8'h00;

    assign sda_line = sda_m & ~sda_oe;

    always #2.5 clk = ~clk;

    dual_page_i2c_mem i_dual_page_i2c_mem (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .sda_oe_o (sda_oe),
        .wp_i     (wp),
        .los_i    (los)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", req, act, exp);
        end
    endtask

    function automatic bit hole(input logic pg, input logic [7:0] off);
        return (!pg && (off == 8'h78 || off == 8'h79)) || (pg && off >= 8'hF0);
    endfunction

    function automatic logic [7:0] exp_rd(input logic pg, input logic [7:0] off);
        if (hole(pg, off)) return 8'hFF;
        if (pg && off == 8'h6E && sff_m) return {7'b0, los};
        return model_q[{pg, off}];
    endfunction

    function automatic string req_of(input logic pg, input logic [7:0] off);
        if (hole(pg, off)) return "R5";
        if (pg && off == 8'h6E) return "R7";
        if (!pg && off >= 8'h7A && off <= 8'h7F) return "R6";
        return "R3";
    endfunction

    task automatic model_wr(input logic pg, input logic [7:0] off, input logic [7:0] v);
        if (wp || hole(pg, off)) return;
        if (pg && off == 8'h6E && sff_m) return;
        model_q[{pg, off}] = v;
        if (!pg && off == 8'h75) sff_m = v[0];
    endtask

    task automatic clk_bit(input logic drv, output logic seen);
        tick(Q); sda_m = drv;
        tick(H - Q); scl_m = 1'b1;
        tick(Q); seen = sda_line;
        tick(H - Q); scl_m = 1'b0;
    endtask

    task automatic bus_start();
        tick(Q); sda_m = 1'b1;
        tick(H - Q); scl_m = 1'b1;
        tick(Q); sda_m = 1'b0;
        tick(H - Q); scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        tick(Q); sda_m = 1'b0;
        tick(H - Q); scl_m = 1'b1;
        tick(Q); sda_m = 1'b1;
        tick(H - Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        acked = !s;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            b[i] = s;
        end
        clk_bit(!give_ack, s);
    endtask

    task automatic wr_begin(input logic pg, input logic [7:0] off);
        logic a;
        bus_start();
        send_byte({6'b101000, pg, 1'b0}, a);
        check("R1", {7'b0, a}, 8'h01);
        send_byte(off, a);
        check("R2", {7'b0, a}, 8'h01);
        mpage = pg;
        mptr  = off;
    endtask

    task automatic wr_byte(input logic [7:0] v);
        logic a;
        send_byte(v, a);
        check("R2", {7'b0, a}, 8'h01);
        model_wr(mpage, mptr, v);
        mptr = mptr + 8'd1;
    endtask

    task automatic cur_begin(input logic pg);
        logic a;
        bus_start();
        send_byte({6'b101000, pg, 1'b1}, a);
        check("R4", {7'b0, a}, 8'h01);
        mpage = pg;
    endtask

    task automatic rd_begin(input logic pg, input logic [7:0] off);
        wr_begin(pg, off);
        cur_begin(pg);
    endtask

    task automatic rd_byte(input string tag, input bit last);
        logic [7:0] v;
        recv_byte(!last, v);
        check(tag, v, exp_rd(mpage, mptr));
        mptr = mptr + 8'd1;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick(5);
        rst = 1'b0;
        for (int i = 'h7A; i <= 'h7F; i++) model_q[i] = 8'h00;
        tick(5);
    endtask

    initial begin
        logic a;
        logic [7:0] keep;
        do_reset();
        check("R9", {7'b0, sda_oe}, 8'h00);

        // R6: volatile registers come up cleared
        rd_begin(1'b0, 8'h7A);
        for (int i = 0; i < 6; i++) rd_byte("R6", i == 5);
        bus_stop();

        // Full sweep, page 0 from offset 00h (covers R5, R6, mode byte)
        wr_begin(1'b0, 8'h00);
        for (int i = 0; i < 256; i++) wr_byte(8'(i * 7 + 3));
        bus_stop();

        // Page 1 sweep starting at 10h, wrapping through FFh (R3)
        wr_begin(1'b1, 8'h10);
        for (int i = 0; i < 256; i++) wr_byte(8'(i * 13 + 8'h21));
        bus_stop();

        // Read back page 0 plus one byte past the wrap (R3)
        rd_begin(1'b0, 8'h00);
        for (int i = 0; i < 257; i++) rd_byte(req_of(mpage, mptr), i == 256);
        bus_stop();

        // Read back page 1 from F8h across the wrap
        rd_begin(1'b1, 8'hF8);
        for (int i = 0; i < 256; i++) rd_byte(req_of(mpage, mptr), i == 255);
        bus_stop();

        // R7: mode bit on exposes the live status byte
        wr_begin(1'b0, 8'h75);
        wr_byte(8'h01);
        bus_stop();
        los = 1'b1;
        rd_begin(1'b1, 8'h6E);
        rd_byte("R7", 0);
        rd_byte("R7", 1);
        bus_stop();
        los = 1'b0;
        rd_begin(1'b1, 8'h6E);
        rd_byte("R7", 1);
        bus_stop();
        wr_begin(1'b1, 8'h6E);
        wr_byte(8'h77);
        bus_stop();
        rd_begin(1'b1, 8'h6E);
        rd_byte("R7", 1);
        bus_stop();
        wr_begin(1'b0, 8'h75);
        wr_byte(8'h00);
        bus_stop();
        rd_begin(1'b1, 8'h6E);
        rd_byte("R7", 1);
        bus_stop();

        // R8: write protect freezes everything, mode byte included
        wp = 1'b1;
        tick(4);
        keep = model_q[9'h010];
        wr_begin(1'b0, 8'h10);
        wr_byte(~keep);
        wr_byte(8'h5C);
        bus_stop();
        wr_begin(1'b0, 8'h75);
        wr_byte(8'h01);
        bus_stop();
        wp = 1'b0;
        tick(4);
        rd_begin(1'b0, 8'h10);
        rd_byte("R8", 0);
        rd_byte("R8", 1);
        bus_stop();
        los = 1'b1;
        rd_begin(1'b1, 8'h6E);
        rd_byte("R8", 1);
        bus_stop();
        los = 1'b0;

        // R1: a foreign address is refused and the bytes after it are ignored
        bus_start();
        send_byte(8'hA4, a);
        check("R1", {7'b0, a}, 8'h00);
        send_byte(8'h10, a);
        check("R1", {7'b0, a}, 8'h00);
        send_byte(8'h99, a);
        bus_stop();
        rd_begin(1'b0, 8'h10);
        rd_byte("R1", 1);
        bus_stop();

        // R9: STOP in the middle of a data byte discards it
        wr_begin(1'b0, 8'h30);
        for (int i = 0; i < 4; i++) clk_bit(1'b0, a);
        bus_stop();
        cur_begin(1'b0);
        rd_byte("R9", 1);
        bus_stop();
        // R4: next read continues from the current pointer (31h)
        cur_begin(1'b0);
        rd_byte("R4", 1);
        bus_stop();

        // R6: reset clears volatile bytes and keeps nonvolatile ones
        do_reset();
        check("R9", {7'b0, sda_oe}, 8'h00);
        rd_begin(1'b0, 8'h70);
        for (int i = 0; i < 16; i++) rd_byte("R6", i == 15);
        bus_stop();

        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule